// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Exception Entry

This block sequences instruction fetch for a core that runs either full 32-bit instructions or compressed 16-bit instructions. It holds the fetch pointer, the address of the instruction it fetched most recently, and the program-counter value that software sees. It issues one word or halfword request to a simple memory port and waits for the response. When the response arrives, it captures the instruction and reports how many wait states the addressed region costs. The execute stage then asks for the next fetch with a one-cycle `step` pulse.

While an instruction is held, the block can also enter two exceptions: an external interrupt and a prefetch abort. On entry it asks the register file to change mode in the same cycle and supplies the link value and both status words. It also clears the wait-for-interrupt flag and starts a new fetch from the vector address. The vector base is fixed per core instance by a parameter.

Top module: `fetch_seq`

## Requirements
- R1: In a clock edge with `rst_n` low, `fetch_ptr` and `pc_vis` load `start_addr`, `instr_valid` and `wfi_flag` clear, and the block then requests memory at `start_addr`.
- R2: With `cur_status` bit 5 (compressed-state bit) at 0, the request has `mem_half`=0. The response captures `instr`=`mem_rdata` and `instr_addr`=old pointer, advances `fetch_ptr` by 4, and sets `pc_vis` to the new pointer plus 4.
- R3: With `cur_status` bit 5 at 1, the request has `mem_half`=1. The response captures `instr`={16'h0, `mem_rdata[15:0]`}, advances `fetch_ptr` by 2, and sets `pc_vis` to the new pointer plus 2.
- R4: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `fetch_ptr` keep their values. `mem_addr` always equals `fetch_ptr`.
- R5: `wait_cycles` is loaded with the response. It holds entry k of `WS_WORD` (word fetch) or `WS_HALF` (halfword fetch), where k is bits 27:24 of the fetched address and entry k occupies parameter bits 4k+3:4k.
- R6: `instr_valid` rises in the cycle after a response. A `step` while it is high drops it and issues the next sequential request in the following cycle. `step` is ignored while a fetch is outstanding.
- R7: While an instruction is held, `irq_req` with `cur_status` bit 7 (interrupt-disable) at 0 causes entry in that cycle, with these outputs:
  - `mode_sw_req`=1 and `mode_sw_mode`=5'h12;
  - `lr_data`=`instr_addr`+4 and `stat_saved`=`cur_status`;
  - `stat_new` equal to `cur_status` with bits 4:0 set to the new mode, bit 5 cleared and bit 7 set.

  The next fetch then goes to vector base + 0x18. Requests that arrive while a fetch is outstanding are not taken.
- R8: Abort entry via `abt_req` behaves like R7, but uses mode 5'h17 and vector base + 0x0C.
- R9: While `cur_status` bit 7 is set, neither `irq_req` nor `abt_req` is taken, and `step` acts normally.
- R10: When both requests are taken in the same cycle, abort entry wins.
- R11: The vector base is 0xFFFF0000 when `CORE_ID` is 0, and 0x00000000 otherwise.
- R12: `wait_set` sets `wfi_flag`, and exception entry clears it. When both happen in the same cycle, clearing wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | ADDR_W | Fetch address loaded by reset |
| cur_status | input | 32 | Current status word (bit 5 compressed state, bit 7 interrupt disable) |
| step | input | 1 | Request the next sequential fetch |
| irq_req | input | 1 | Interrupt request |
| abt_req | input | 1 | Prefetch-abort request |
| wait_set | input | 1 | Set the wait-for-interrupt flag |
| mem_req | output | 1 | Fetch request pending |
| mem_addr | output | ADDR_W | Fetch address |
| mem_half | output | 1 | 1 = halfword fetch, 0 = word fetch |
| mem_ack | input | 1 | Response valid for the pending request |
| mem_rdata | input | 32 | Response data |
| instr_valid | output | 1 | An instruction is held |
| instr | output | 32 | Held instruction |
| instr_addr | output | ADDR_W | Address of the held instruction |
| fetch_ptr | output | ADDR_W | Next fetch address |
| pc_vis | output | ADDR_W | Program-counter value seen by software |
| wait_cycles | output | 4 | Wait states of the last fetch |
| wfi_flag | output | 1 | Wait-for-interrupt flag |
| mode_sw_req | output | 1 | Exception entry this cycle; mode switch request |
| mode_sw_mode | output | 5 | Target mode code |
| lr_data | output | ADDR_W | Value for link register 14 |
| stat_new | output | 32 | Status word to install |
| stat_saved | output | 32 | Status word to save |

## Verification
A behavioural model in the bench tracks the pointer, the visible PC and the held instruction, and compares them with the design every cycle.

Directed phases come first:
- delayed responses separate the hold-while-waiting rule from an immediate advance;
- an interrupt and an abort raised together show the priority;
- a masked request shows suppression;
- a state flip into compressed mode separates the +2 from the +4 arithmetic.

Random traffic then mixes response delays, steps, requests, mask changes and resets at new start addresses in many regions. This exercises the wait-state lookup for both tables. A second instance with the other core identity checks the alternate vector base.

// File: rtl/fs_pkg.sv
// Shared types and constants for the fetch sequencer.
// Assumes a 32-bit status word with the mode in bits 4:0.
package fs_pkg;
    localparam int STATUS_W   = 32;
    localparam int INSTR_W    = 32;
    localparam int HALF_W     = 16;
    localparam int WS_ENTRIES = 16;
    localparam int WS_W       = 4;
    localparam int MODE_W     = 5;
    localparam int ST_T_BIT   = 5;
    localparam int ST_I_BIT   = 7;
    localparam int REGION_LO  = 24;

    typedef enum logic {
        FS_BUSY = 1'b0,
        FS_HOLD = 1'b1
    } fs_state_e;

    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;

    localparam logic [7:0] OFS_IRQ = 8'h18;
    localparam logic [7:0] OFS_ABT = 8'h0C;

    // Builds the status word installed on exception entry.
    function automatic logic [STATUS_W-1:0] entry_status(
        input logic [STATUS_W-1:0] old_st,
        input logic [MODE_W-1:0]   mode
    );
        logic [STATUS_W-1:0] s;
        s                = old_st;
        s[MODE_W-1:0]    = mode;
        s[ST_T_BIT]      = 1'b0;
        s[ST_I_BIT]      = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/fs_wait_lut.sv
// Wait-state lookup: unpacks a packed parameter into a per-region table
// and selects the entry for the given region. Entry k sits at bits 4k+3:4k.
module fs_wait_lut
    import fs_pkg::*;
#(
    parameter logic [WS_ENTRIES*WS_W-1:0] TABLE = '0
) (
    input  logic [$clog2(WS_ENTRIES)-1:0] region,
    output logic [WS_W-1:0]               cycles
);
    logic [WS_W-1:0] entry [WS_ENTRIES];

    // Unpack each table entry from the parameter.
    for (genvar g = 0; g < WS_ENTRIES; g++) begin : g_entry
        assign entry[g] = TABLE[g*WS_W +: WS_W];
    end

    // Select the entry for the region.
    assign cycles = entry[region];
endmodule

// File: rtl/fs_fetch_math.sv
// Address arithmetic and data lane selection for one fetch.
// Assumes halfword responses arrive in the low 16 bits of the data bus.
module fs_fetch_math
    import fs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  ptr,
    input  logic               half,
    input  logic [INSTR_W-1:0] rdata,
    output logic [ADDR_W-1:0]  next_ptr,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [INSTR_W-1:0] instr_word
);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_H = ADDR_W'(2);

    logic [ADDR_W-1:0] stride;

    // Pick stride and instruction lane by width.
    always_comb begin
        stride     = half ? STEP_H : STEP_W;
        next_ptr   = ptr + stride;
        next_pc    = next_ptr + stride;
        instr_word = half ? {{(INSTR_W-HALF_W){1'b0}}, rdata[HALF_W-1:0]} : rdata;
    end
endmodule

// File: rtl/fs_exc_arbiter.sv
// Decides exception entry: only while an instruction is held and the
// interrupt-disable bit is clear; abort wins over interrupt.
module fs_exc_arbiter
    import fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              masked,
    input  logic              irq,
    input  logic              abt,
    output logic              take,
    output logic [MODE_W-1:0] mode,
    output logic [7:0]        offset
);
    // Gate requests and apply the fixed priority.
    always_comb begin
        take   = hold && !masked && (irq || abt);
        mode   = abt ? MODE_ABT : MODE_IRQ;
        offset = abt ? OFS_ABT : OFS_IRQ;
    end

    assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !take);
    assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq && abt) |-> (mode == MODE_ABT && offset == OFS_ABT));
    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> !take);
endmodule

// File: rtl/fetch_seq.sv
// Fetch sequencer: issues word/halfword fetches, tracks fetch pointer,
// instruction address and visible PC, reports wait states, and performs
// interrupt and prefetch-abort entry. Assumes cur_status is stable while
// a fetch is outstanding except through this block's own entry writes.
module fetch_seq
    import fs_pkg::*;
#(
    parameter int                          ADDR_W  = 32,
    parameter int                          CORE_ID = 0,
    parameter logic [WS_ENTRIES*WS_W-1:0]  WS_WORD = 64'h3322_1111_2211_5511,
    parameter logic [WS_ENTRIES*WS_W-1:0]  WS_HALF = 64'h1111_0000_1100_2200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [STATUS_W-1:0]  cur_status,
    input  logic                 step,
    input  logic                 irq_req,
    input  logic                 abt_req,
    input  logic                 wait_set,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_half,
    input  logic                 mem_ack,
    input  logic [INSTR_W-1:0]   mem_rdata,
    output logic                 instr_valid,
    output logic [INSTR_W-1:0]   instr,
    output logic [ADDR_W-1:0]    instr_addr,
    output logic [ADDR_W-1:0]    fetch_ptr,
    output logic [ADDR_W-1:0]    pc_vis,
    output logic [WS_W-1:0]      wait_cycles,
    output logic                 wfi_flag,
    output logic                 mode_sw_req,
    output logic [MODE_W-1:0]    mode_sw_mode,
    output logic [ADDR_W-1:0]    lr_data,
    output logic [STATUS_W-1:0]  stat_new,
    output logic [STATUS_W-1:0]  stat_saved
);
    localparam int RB = $clog2(WS_ENTRIES);
    localparam logic [ADDR_W-1:0] VEC_BASE =
        (CORE_ID == 0) ? ({ADDR_W{1'b1}} << 16) : '0;

    fs_state_e           state_q;
    logic                half_mode;
    logic                fetch_done;
    logic [ADDR_W-1:0]   nxt_ptr;
    logic [ADDR_W-1:0]   nxt_pc;
    logic [INSTR_W-1:0]  word_in;
    logic [WS_W-1:0]     ws_word;
    logic [WS_W-1:0]     ws_half;
    logic                exc_take;
    logic [MODE_W-1:0]   exc_mode;
    logic [7:0]          exc_ofs;
    logic [ADDR_W-1:0]   vec_addr;

    assign half_mode  = cur_status[ST_T_BIT];
    assign mem_req    = (state_q == FS_BUSY);
    assign mem_addr   = fetch_ptr;
    assign mem_half   = half_mode;
    assign fetch_done = mem_req && mem_ack;
    assign vec_addr   = VEC_BASE + ADDR_W'(exc_ofs);

    fs_fetch_math #(.ADDR_W(ADDR_W)) u_math (
        .ptr        (fetch_ptr),
        .half       (half_mode),
        .rdata      (mem_rdata),
        .next_ptr   (nxt_ptr),
        .next_pc    (nxt_pc),
        .instr_word (word_in)
    );

    fs_wait_lut #(.TABLE(WS_WORD)) u_ws_word (
        .region (fetch_ptr[REGION_LO +: RB]),
        .cycles (ws_word)
    );

    fs_wait_lut #(.TABLE(WS_HALF)) u_ws_half (
        .region (fetch_ptr[REGION_LO +: RB]),
        .cycles (ws_half)
    );

    fs_exc_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (state_q == FS_HOLD),
        .masked (cur_status[ST_I_BIT]),
        .irq    (irq_req),
        .abt    (abt_req),
        .take   (exc_take),
        .mode   (exc_mode),
        .offset (exc_ofs)
    );

    // Drive the entry side-band toward the register file.
    always_comb begin
        mode_sw_req  = exc_take;
        mode_sw_mode = exc_mode;
        lr_data      = instr_addr + ADDR_W'(4);
        stat_saved   = cur_status;
        stat_new     = entry_status(cur_status, exc_mode);
    end

    // Fetch state, pointer, PC and captured instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_BUSY;
            fetch_ptr   <= start_addr;
            pc_vis      <= start_addr;
            instr_valid <= 1'b0;
            instr       <= '0;
            instr_addr  <= '0;
            wait_cycles <= '0;
        end else if (state_q == FS_BUSY) begin
            if (mem_ack) begin
                state_q     <= FS_HOLD;
                instr       <= word_in;
                instr_addr  <= fetch_ptr;
                fetch_ptr   <= nxt_ptr;
                pc_vis      <= nxt_pc;
                wait_cycles <= half_mode ? ws_half : ws_word;
                instr_valid <= 1'b1;
            end
        end else if (exc_take) begin
            state_q     <= FS_BUSY;
            fetch_ptr   <= vec_addr;
            pc_vis      <= vec_addr;
            instr_valid <= 1'b0;
        end else if (step) begin
            state_q     <= FS_BUSY;
            instr_valid <= 1'b0;
        end
    end

    // Wait-for-interrupt flag: entry clears, wait_set sets.
    always_ff @(posedge clk) begin
        if (!rst_n)          wfi_flag <= 1'b0;
        else if (exc_take)   wfi_flag <= 1'b0;
        else if (wait_set)   wfi_flag <= 1'b1;
    end

    assert_hold_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(fetch_ptr)));
    assert_word_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && !mem_half) |=> (instr_valid && pc_vis == fetch_ptr + ADDR_W'(4)));
    assert_half_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && mem_half) |=> (instr_valid && pc_vis == fetch_ptr + ADDR_W'(2)));
    assert_wfi_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw_req |=> !wfi_flag);
    assert_vec_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sw_req |=> (mem_req && !instr_valid && pc_vis == fetch_ptr
                         && fetch_ptr[ADDR_W-1:16] == VEC_BASE[ADDR_W-1:16]));
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && step && !mode_sw_req) |=> (mem_req && !instr_valid));
endmodule

// File: tb/test_fetch_seq.sv
module test_fetch_seq;
    localparam logic [63:0] TW = 64'h3322_1111_2211_5511;
    localparam logic [63:0] TH = 64'h1111_0000_1100_2200;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, step, irq_req, abt_req, wait_set, ack_gate, flip_t, flip_i;
    logic [31:0] start_addr, status;
    logic        mem_req, mem_half, mem_ack, instr_valid, wfi_flag, mode_sw_req;
    logic [31:0] mem_addr, mem_rdata, instr, instr_addr, fetch_ptr, pc_vis, lr_data;
    logic [31:0] stat_new, stat_saved;
    logic [3:0]  wait_cycles;
    logic [4:0]  mode_sw_mode;

    logic        b_req, b_half, b_iv, b_wfi, b_msr;
    logic [31:0] b_addr, b_instr, b_iaddr, b_ptr, b_pc, b_lr, b_sn, b_ss;
    logic [3:0]  b_wc;
    logic [4:0]  b_mode;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return {a[31:16] ^ a[15:0], a[15:0] ^ 16'hC3A5};
    endfunction

    assign mem_ack   = mem_req && ack_gate;
    assign mem_rdata = mdata(mem_addr);

    fetch_seq #(.ADDR_W(32), .CORE_ID(0), .WS_WORD(TW), .WS_HALF(TH)) i_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .cur_status(status),
        .step(step), .irq_req(irq_req), .abt_req(abt_req), .wait_set(wait_set),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .instr_valid(instr_valid),
        .instr(instr), .instr_addr(instr_addr), .fetch_ptr(fetch_ptr),
        .pc_vis(pc_vis), .wait_cycles(wait_cycles), .wfi_flag(wfi_flag),
        .mode_sw_req(mode_sw_req), .mode_sw_mode(mode_sw_mode), .lr_data(lr_data),
        .stat_new(stat_new), .stat_saved(stat_saved));

    fetch_seq #(.ADDR_W(32), .CORE_ID(1), .WS_WORD(TW), .WS_HALF(TH)) i_fetch_seq_alt (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .cur_status(status),
        .step(step), .irq_req(irq_req), .abt_req(abt_req), .wait_set(wait_set),
        .mem_req(b_req), .mem_addr(b_addr), .mem_half(b_half),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .instr_valid(b_iv),
        .instr(b_instr), .instr_addr(b_iaddr), .fetch_ptr(b_ptr),
        .pc_vis(b_pc), .wait_cycles(b_wc), .wfi_flag(b_wfi),
        .mode_sw_req(b_msr), .mode_sw_mode(b_mode), .lr_data(b_lr),
        .stat_new(b_sn), .stat_saved(b_ss));

    // Reference model state
    bit          m_init = 0, m_busy, m_valid, m_wfi, m_lasthalf;
    logic [31:0] m_ptr, m_pc, m_iaddr, m_instr, m_off;
    logic [3:0]  m_ws;
    int          m_since;
    int          vectors = 0, fails = 0, cycles = 0;

    function automatic logic [3:0] nib(input logic [63:0] t, input logic [3:0] r);
        return t[r*4 +: 4];
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_init = 1; m_busy = 1; m_valid = 0; m_wfi = 0; m_since = 0;
            m_ptr = start_addr; m_pc = start_addr; m_off = 0; m_lasthalf = 0;
        end else if (m_init) begin
            m_since++;
            if (m_busy) begin
                if (wait_set) m_wfi = 1;
                if (ack_gate) begin
                    m_lasthalf = status[5];
                    m_iaddr = m_ptr;
                    m_instr = status[5] ? {16'h0, mdata(m_ptr)[15:0]} : mdata(m_ptr);
                    m_ws = status[5] ? nib(TH, m_ptr[27:24]) : nib(TW, m_ptr[27:24]);
                    m_ptr = m_ptr + (status[5] ? 2 : 4);
                    m_pc = m_ptr + (status[5] ? 2 : 4);
                    m_valid = 1; m_busy = 0;
                end
            end else if (!status[7] && (irq_req || abt_req)) begin
                m_ptr = 32'hFFFF_0000 + (abt_req ? 32'h0C : 32'h18);
                m_pc = m_ptr; m_off = 32'hFFFF_0000;
                m_valid = 0; m_busy = 1; m_wfi = 0;
                status <= {status[31:8], 1'b1, status[6], 1'b0, abt_req ? 5'h17 : 5'h12};
            end else begin
                if (wait_set) m_wfi = 1;
                if (step) begin
                    m_valid = 0; m_busy = 1;
                end else begin
                    status <= status ^ {24'h0, flip_i, 1'b0, flip_t, 5'h0};
                end
            end
        end
    end

    task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, nm, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (m_init) begin
            string rp, rf, re;
            logic  hit;
            rp = (m_since == 0) ? "R1" : (m_lasthalf ? "R3" : "R2");
            chk(rp, "fetch_ptr", fetch_ptr, m_ptr);
            chk(rp, "pc_vis", pc_vis, m_pc);
            chk(m_since == 0 ? "R1" : "R4", "mem_req", {31'h0, mem_req}, {31'h0, m_busy});
            chk("R4", "mem_addr", mem_addr, m_ptr);
            chk(m_since == 0 ? "R1" : "R6", "instr_valid", {31'h0, instr_valid}, {31'h0, m_valid});
            chk(m_since == 0 ? "R1" : "R12", "wfi_flag", {31'h0, wfi_flag}, {31'h0, m_wfi});
            chk("R11", "alt fetch_ptr", b_ptr, m_ptr - m_off);
            if (m_busy) chk(status[5] ? "R3" : "R2", "mem_half", {31'h0, mem_half}, {31'h0, status[5]});
            if (m_valid) begin
                rf = m_lasthalf ? "R3" : "R2";
                chk(rf, "instr", instr, m_instr);
                chk(rf, "instr_addr", instr_addr, m_iaddr);
                chk("R5", "wait_cycles", {28'h0, wait_cycles}, {28'h0, m_ws});
            end
            hit = !m_busy && !status[7] && (irq_req || abt_req);
            if (!m_busy && status[7] && (irq_req || abt_req)) re = "R9";
            else if (irq_req && abt_req) re = "R10";
            else if (abt_req) re = "R8";
            else re = "R7";
            chk(re, "mode_sw_req", {31'h0, mode_sw_req}, {31'h0, hit});
            if (hit) begin
                chk(re, "mode_sw_mode", {27'h0, mode_sw_mode}, abt_req ? 32'h17 : 32'h12);
                chk(re, "lr_data", lr_data, m_iaddr + 4);
                chk(re, "stat_saved", stat_saved, status);
                chk(re, "stat_new", stat_new,
                    {status[31:8], 1'b1, status[6], 1'b0, abt_req ? 5'h17 : 5'h12});
            end
        end
    end

    task automatic cyc(input bit s, input bit ir, input bit ab, input bit w,
                       input bit a, input bit ft, input bit fi);
        @(negedge clk);
        rst_n = 1; step = s; irq_req = ir; abt_req = ab; wait_set = w;
        ack_gate = a; flip_t = ft; flip_i = fi;
    endtask

    task automatic do_reset(input logic [31:0] addr);
        @(negedge clk);
        rst_n = 0; start_addr = addr; step = 0; irq_req = 0; abt_req = 0;
        wait_set = 0; ack_gate = 0; flip_t = 0; flip_i = 0;
    endtask

    initial begin
        status = 32'h0000_001F;
        do_reset(32'h0200_0000);
        do_reset(32'h0200_0000);
        cyc(0,0,0,0,0,0,0);               // R4: waiting, pointer held
        cyc(0,0,0,0,0,0,0);
        cyc(0,0,0,0,1,0,0);               // R2: word fetch completes
        cyc(1,0,0,0,0,0,0);               // R6: step
        cyc(0,0,0,1,1,0,0);               // R12: set wait flag during fetch
        cyc(0,1,1,0,0,0,0);               // R10: both requests, abort wins
        cyc(0,0,0,0,1,0,0);               // R8/R11: vector fetch
        cyc(0,1,0,0,0,0,0);               // R9: masked interrupt
        cyc(0,0,0,1,0,0,1);               // unmask, set wait flag
        cyc(0,1,0,0,0,0,0);               // R7, R12: interrupt entry clears flag
        cyc(0,0,0,0,1,0,0);
        cyc(0,0,0,0,0,1,1);               // R3: enter compressed state, unmask
        cyc(1,0,0,0,0,0,0);
        cyc(0,0,0,0,1,0,0);               // R3: halfword fetch
        cyc(1,0,0,0,1,0,0);
        cyc(0,0,0,0,1,0,0);
        for (int n = 0; n < 3000; n++) begin
            if (n % 350 == 349) begin
                do_reset($urandom & 32'hFFFF_FFFE);
                @(negedge clk); status = status & 32'hFFFF_FF5F;
            end else begin
                cyc(($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 20) == 0,
                    ($urandom % 20) == 0, ($urandom % 5) < 3,
                    ($urandom % 10) == 0, ($urandom % 5) == 0);
            end
        end
        cyc(0,0,0,0,0,0,0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(5ns * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule